// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block brings a set of supply outputs up in an orderly way once the standby rail is healthy, and then watches them for trouble. A digital ramp code stands in for the soft-start capacitor voltage. After a power-on delay the ramp jumps to a low starting code and climbs slowly to a clamp code. It waits there until the memory-voltage selection has been sampled. It then climbs to a top code. At that point undervoltage monitoring switches on and the ramp drops back to the clamp code.

The sequencer has eight named states. `SEQ_OFF` means the standby rail is below threshold. `SEQ_PORWAIT` counts the power-on delay. `SEQ_FAST` loads the starting code. `SEQ_CHARGE` climbs to the clamp. `SEQ_HOLD` waits for the selection sample. `SEQ_RAMP` climbs to the top. `SEQ_RUN` is normal operation with monitoring on. `SEQ_SHDN` means outputs are off.

The transitions are:
- OFF→PORWAIT when the rail is good.
- PORWAIT→FAST when the delay expires.
- FAST→CHARGE always.
- CHARGE→HOLD when the ramp reaches the clamp.
- HOLD→RAMP when the selection has been sampled.
- RAMP→RUN when the ramp reaches the top.
- Any state from FAST to RUN →SHDN when a shutdown request or a thermal latch is present.
- SHDN→FAST once both are gone.
- Any state →OFF when the rail drops.

Undervoltage flags from enabled outputs, and a warning-level over-temperature flag, are merged into one fault output. A fault is only reported and never turns anything off. A critical-level over-temperature latches a shutdown that only a loss of the standby rail clears.

Top module: `softstart_supervisor`

## Requirements
- R1: After `por_ok` has been high for `POR_DLY` consecutive clock edges, the next edge leaves the wait state (`pwr_kill` falls). A drop of `por_ok` before then restarts the count.
- R2: The ramp loads `CODE_FAST` one edge after `pwr_kill` falls. It then rises by exactly one code every `STEP_DIV` edges until it reaches `CODE_CLAMP`, and holds there while the selection sample is pending.
- R3: `vsel` takes the value of `msel_in` on the edge that follows `POR_DLY + SEL_DLY` edges of good `por_ok`. The capture happens once per power-on event, and `vsel` keeps that value through shutdowns and later changes of `msel_in`.
- R4: Once the selection has been captured, the ramp never decreases until it reaches `CODE_TOP`. On the next edge `uv_en` rises and the ramp returns to `CODE_CLAMP`.
- R5: An undervoltage flag has no effect on `fault` while `uv_en` is low, or while that output's bit in `out_en` is 0 (bit i of both buses refers to output i).
- R6: When `uv_en` is high and any output with `out_en` set has its `uv_flags` bit high for `UV_DLY` consecutive edges, `fault` goes high. It falls one edge after the condition clears. It never changes `pwr_kill`, `uv_en` or `ramp`.
- R7: `ot_lo` high drives `fault` high at once, while operation continues (`pwr_kill` stays 0 and `uv_en` stays 1).
- R8: While `shdn_req` is high, `fault` is 0. One edge after `shdn_req` is asserted, `pwr_kill` is 1, `ramp` is 0 and `uv_en` is 0. Releasing it restarts the sequence at `SEQ_FAST` without a new power-on delay.
- R9: A single-cycle `ot_hi` pulse latches a shutdown. `fault` is 1 one edge later and `pwr_kill` is 1 two edges later. Both stay set after `ot_hi` falls and after a `shdn_req` pulse.
- R10: `por_ok` low forces the `SEQ_OFF` state on the next edge, with `pwr_kill` 1, `ramp` 0, `uv_en` 0, and the thermal latch cleared (`fault` 0).
- R11: While `rst_n` is low the outputs are `pwr_kill`=1, `ramp`=0, `uv_en`=0, `vsel`=0 and `fault`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Standby rail above its power-on threshold |
| msel_in | input | 1 | Memory-voltage select comparator bit (1 = higher voltage) |
| uv_flags | input | N_OUT | Per-output undervoltage comparator flags |
| out_en | input | N_OUT | Per-output enable; disabled outputs are not monitored |
| ot_lo | input | 1 | Over-temperature warning level reached |
| ot_hi | input | 1 | Over-temperature critical level reached |
| shdn_req | input | 1 | External shutdown request (soft-start node held low) |
| ramp | output | RAMP_W | Soft-start ramp code |
| uv_en | output | 1 | Undervoltage monitoring active |
| vsel | output | 1 | Latched memory-voltage selection |
| fault | output | 1 | Combined fault report |
| pwr_kill | output | 1 | All outputs held off |

## Verification
The fault merge is driven from a table of undervoltage, enable and warning-temperature patterns. These cover a flag on an enabled output, a flag on a disabled output, all flags with no enables, and warning temperature alone. Together they separate the masking by `out_en` from the OR across outputs and from the temperature path. A separate pattern holds every flag high throughout the ramp, which shows that monitoring stays off until `SEQ_RUN`.

The sequence is timed edge by edge: the power-on delay after a rail glitch, the first ramp steps, and the exact capture edge of `vsel`. The capture is run twice with different select values, so a held value can be told apart from a fresh capture. Shutdown and thermal tests check the forced-low fault, the latch surviving a shutdown pulse, and the clearing only by loss of the rail.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF,
        SEQ_PORWAIT,
        SEQ_FAST,
        SEQ_CHARGE,
        SEQ_HOLD,
        SEQ_RAMP,
        SEQ_RUN,
        SEQ_SHDN
    } seq_state_e;

endpackage

// File: rtl/ss_sat_count.sv
module ss_sat_count #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == CW'(LIMIT));

    // R1
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clr |=> done);

endmodule

// File: rtl/ss_fault_mon.sv
module ss_fault_mon #(
    parameter int unsigned N_OUT  = 3,
    parameter int unsigned UV_DLY = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             uv_en,
    input  logic [N_OUT-1:0] uv_flags,
    input  logic [N_OUT-1:0] out_en,
    input  logic             ot_lo,
    input  logic             ot_hi,
    input  logic             shdn_req,
    output logic             therm_lat,
    output logic             fault
);
    logic uv_seen;
    logic uv_fault;
    logic therm_q;

    assign uv_seen = uv_en && |(uv_flags & out_en);

    ss_sat_count #(.LIMIT(UV_DLY)) u_uv_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!uv_seen),
        .done  (uv_fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            therm_q <= 1'b0;
        end else if (!por_ok) begin
            therm_q <= 1'b0;
        end else if (ot_hi) begin
            therm_q <= 1'b1;
        end
    end

    always_comb begin
        therm_lat = therm_q;
        fault     = !shdn_req && (uv_fault || ot_lo || therm_q);
    end

    // R9
    therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_q && por_ok |=> therm_q);

    // R5
    uv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_en |=> !uv_fault);

endmodule

// File: rtl/ss_seq.sv
module ss_seq
    import ss_pkg::*;
#(
    parameter int unsigned RAMP_W     = 8,
    parameter int unsigned STEP_DIV   = 4,
    parameter int unsigned CODE_FAST  = 80,
    parameter int unsigned CODE_CLAMP = 100,
    parameter int unsigned CODE_TOP   = 224,
    parameter int unsigned POR_DLY    = 330,
    parameter int unsigned SEL_DLY    = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              kill,
    input  logic              msel_in,
    output logic [RAMP_W-1:0] ramp,
    output logic              uv_en,
    output logic              vsel,
    output logic              pwr_kill
);
    localparam int unsigned SW = $clog2(STEP_DIV + 1);
    localparam logic [RAMP_W-1:0] R_FAST  = RAMP_W'(CODE_FAST);
    localparam logic [RAMP_W-1:0] R_CLAMP = RAMP_W'(CODE_CLAMP);
    localparam logic [RAMP_W-1:0] R_TOP   = RAMP_W'(CODE_TOP);

    seq_state_e        state_q, state_d;
    logic [RAMP_W-1:0] ramp_q, ramp_d;
    logic [SW-1:0]     step_q;
    logic              tick;
    logic              por_done;
    logic              sel_done;
    logic              sel_taken_q;
    logic              vsel_q;
    logic              ramping;

    ss_sat_count #(.LIMIT(POR_DLY)) u_por_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!por_ok),
        .done  (por_done)
    );

    ss_sat_count #(.LIMIT(SEL_DLY)) u_sel_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!por_done),
        .done  (sel_done)
    );

    assign ramping = (state_q == SEQ_CHARGE) || (state_q == SEQ_RAMP);
    assign tick    = ramping && (step_q == SW'(STEP_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (!ramping || tick) begin
            step_q <= '0;
        end else begin
            step_q <= step_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!por_ok) begin
            state_d = SEQ_OFF;
        end else if (kill && (state_q inside {SEQ_FAST, SEQ_CHARGE, SEQ_HOLD,
                                              SEQ_RAMP, SEQ_RUN})) begin
            state_d = SEQ_SHDN;
        end else begin
            unique case (state_q)
                SEQ_OFF:     state_d = SEQ_PORWAIT;
                SEQ_PORWAIT: if (por_done) state_d = SEQ_FAST;
                SEQ_FAST:    state_d = SEQ_CHARGE;
                SEQ_CHARGE:  if (ramp_q == R_CLAMP) state_d = SEQ_HOLD;
                SEQ_HOLD:    if (sel_done) state_d = SEQ_RAMP;
                SEQ_RAMP:    if (ramp_q == R_TOP) state_d = SEQ_RUN;
                SEQ_RUN:     state_d = SEQ_RUN;
                SEQ_SHDN:    if (!kill) state_d = SEQ_FAST;
                default:     state_d = SEQ_OFF;
            endcase
        end
    end

    always_comb begin
        if (state_d inside {SEQ_OFF, SEQ_PORWAIT, SEQ_SHDN}) begin
            ramp_d = '0;
        end else if (state_d == SEQ_RUN) begin
            ramp_d = R_CLAMP;
        end else begin
            unique case (state_q)
                SEQ_FAST:   ramp_d = R_FAST;
                SEQ_CHARGE: ramp_d = (tick && ramp_q != R_CLAMP) ? ramp_q + 1'b1 : ramp_q;
                SEQ_RAMP:   ramp_d = (tick && ramp_q != R_TOP) ? ramp_q + 1'b1 : ramp_q;
                default:    ramp_d = ramp_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
            ramp_q  <= '0;
        end else begin
            state_q <= state_d;
            ramp_q  <= ramp_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_taken_q <= 1'b0;
            vsel_q      <= 1'b0;
        end else if (!por_ok) begin
            sel_taken_q <= 1'b0;
        end else if (sel_done && !sel_taken_q) begin
            sel_taken_q <= 1'b1;
            vsel_q      <= msel_in;
        end
    end

    always_comb begin
        ramp     = ramp_q;
        vsel     = vsel_q;
        uv_en    = (state_q == SEQ_RUN);
        pwr_kill = (state_q == SEQ_OFF) || (state_q == SEQ_PORWAIT) ||
                   (state_q == SEQ_SHDN);
    end

    // R4
    uv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_en) |-> $past(ramp_q) == R_TOP);

    // R4
    ramp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_q <= R_TOP);

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_taken_q && por_ok |=> $stable(vsel_q));

    // R10
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> state_q == SEQ_OFF && ramp_q == '0);

endmodule

// File: rtl/softstart_supervisor.sv
module softstart_supervisor #(
    parameter int unsigned N_OUT      = 3,
    parameter int unsigned RAMP_W     = 8,
    parameter int unsigned STEP_DIV   = 4,
    parameter int unsigned CODE_FAST  = 80,
    parameter int unsigned CODE_CLAMP = 100,
    parameter int unsigned CODE_TOP   = 224,
    parameter int unsigned POR_DLY    = 330,
    parameter int unsigned SEL_DLY    = 300,
    parameter int unsigned UV_DLY     = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              msel_in,
    input  logic [N_OUT-1:0]  uv_flags,
    input  logic [N_OUT-1:0]  out_en,
    input  logic              ot_lo,
    input  logic              ot_hi,
    input  logic              shdn_req,
    output logic [RAMP_W-1:0] ramp,
    output logic              uv_en,
    output logic              vsel,
    output logic              fault,
    output logic              pwr_kill
);
    logic therm_lat;
    logic kill;

    assign kill = shdn_req || therm_lat;

    ss_seq #(
        .RAMP_W     (RAMP_W),
        .STEP_DIV   (STEP_DIV),
        .CODE_FAST  (CODE_FAST),
        .CODE_CLAMP (CODE_CLAMP),
        .CODE_TOP   (CODE_TOP),
        .POR_DLY    (POR_DLY),
        .SEL_DLY    (SEL_DLY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_ok   (por_ok),
        .kill     (kill),
        .msel_in  (msel_in),
        .ramp     (ramp),
        .uv_en    (uv_en),
        .vsel     (vsel),
        .pwr_kill (pwr_kill)
    );

    ss_fault_mon #(
        .N_OUT  (N_OUT),
        .UV_DLY (UV_DLY)
    ) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_ok    (por_ok),
        .uv_en     (uv_en),
        .uv_flags  (uv_flags),
        .out_en    (out_en),
        .ot_lo     (ot_lo),
        .ot_hi     (ot_hi),
        .shdn_req  (shdn_req),
        .therm_lat (therm_lat),
        .fault     (fault)
    );

    // R8
    shdn_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req && !pwr_kill |=> pwr_kill);

    // R8
    kill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_kill |-> ramp == '0 && !uv_en);

endmodule

// File: tb/softstart_supervisor_tb_top.sv
`timescale 1ns/1ps
module softstart_supervisor_tb_top;

    localparam int N_OUT  = 3;
    localparam int RW     = 8;
    localparam int STEP   = 2;
    localparam int C_FAST = 8;
    localparam int C_CLMP = 12;
    localparam int C_TOP  = 40;
    localparam int P_DLY  = 10;
    localparam int S_DLY  = 30;
    localparam int U_DLY  = 5;

    // {uv_flags[2:0], out_en[2:0], ot_lo, expected fault}
    localparam logic [7:0] VECS [0:7] = '{
        8'b001_111_0_1,
        8'b010_101_0_0,
        8'b100_100_0_1,
        8'b000_111_0_0,
        8'b111_000_0_0,
        8'b000_000_1_1,
        8'b110_011_0_1,
        8'b011_100_0_0
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             por_ok = 1'b0;
    logic             msel_in = 1'b0;
    logic [N_OUT-1:0] uv_flags = '0;
    logic [N_OUT-1:0] out_en = '0;
    logic             ot_lo = 1'b0;
    logic             ot_hi = 1'b0;
    logic             shdn_req = 1'b0;
    logic [RW-1:0]    ramp;
    logic             uv_en;
    logic             vsel;
    logic             fault;
    logic             pwr_kill;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    softstart_supervisor #(
        .N_OUT(N_OUT), .RAMP_W(RW), .STEP_DIV(STEP), .CODE_FAST(C_FAST),
        .CODE_CLAMP(C_CLMP), .CODE_TOP(C_TOP), .POR_DLY(P_DLY),
        .SEL_DLY(S_DLY), .UV_DLY(U_DLY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .msel_in(msel_in),
        .uv_flags(uv_flags), .out_en(out_en), .ot_lo(ot_lo), .ot_hi(ot_hi),
        .shdn_req(shdn_req), .ramp(ramp), .uv_en(uv_en), .vsel(vsel),
        .fault(fault), .pwr_kill(pwr_kill)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_run(input string req);
        int prev = 0;
        int top_seen = 0;
        bit seen = 1'b0;
        uv_flags = '1;
        out_en   = '1;
        for (int k = 0; k < 400; k++) begin
            step(1);
            if (uv_en) begin
                seen = 1'b1;
                break;
            end
            chk("R5 fault during ramp-up", int'(fault), 0);
            if (int'(ramp) < prev) chk({req, " ramp decreased"}, int'(ramp), prev);
            prev = int'(ramp);
            if (int'(ramp) > top_seen) top_seen = int'(ramp);
        end
        uv_flags = '0;
        chk({req, " reached run"}, int'(seen), 1);
        chk({req, " peak code"}, top_seen, C_TOP);
        chk({req, " code after top"}, int'(ramp), C_CLMP);
    endtask

    task automatic power_up(input logic before_v, input logic after_v);
        msel_in = after_v;
        por_ok  = 1'b1;
        step(P_DLY);
        chk("R1 still waiting", int'(pwr_kill), 1);
        step(1);
        chk("R1 released", int'(pwr_kill), 0);
        step(1);
        chk("R2 fast code", int'(ramp), C_FAST);
        step(2);
        chk("R2 first step", int'(ramp), C_FAST + 1);
        step(2);
        chk("R2 second step", int'(ramp), C_FAST + 2);
        step(S_DLY - 6);
        chk("R3 before capture", int'(vsel), int'(before_v));
        chk("R2 holding at clamp", int'(ramp), C_CLMP);
        chk("R2 no monitor yet", int'(uv_en), 0);
        step(1);
        chk("R3 captured", int'(vsel), int'(after_v));
        msel_in = ~after_v;
        wait_run("R4");
    endtask

    initial begin
        logic [7:0] v;
        string tag;
        step(2);
        chk("R11 pwr_kill", int'(pwr_kill), 1);
        chk("R11 ramp", int'(ramp), 0);
        chk("R11 uv_en", int'(uv_en), 0);
        chk("R11 vsel", int'(vsel), 0);
        chk("R11 fault", int'(fault), 0);
        rst_n = 1'b1;
        step(1);

        // R1: a glitch on por_ok restarts the power-on count
        por_ok = 1'b1;
        step(P_DLY - 2);
        por_ok = 1'b0;
        step(2);
        chk("R1 glitch keeps off", int'(pwr_kill), 1);
        power_up(1'b0, 1'b1);

        // R5 R6 R7: pattern table
        for (int i = 0; i < 8; i++) begin
            v = VECS[i];
            uv_flags = v[7:5];
            out_en   = v[4:2];
            ot_lo    = v[1];
            tag = v[1] ? "R7" : (v[0] ? "R6" : "R5");
            step(U_DLY + 1);
            chk({tag, " fault pattern"}, int'(fault), int'(v[0]));
            chk({tag, " outputs stay on"}, int'(pwr_kill), 0);
            chk({tag, " monitor stays on"}, int'(uv_en), 1);
            chk({tag, " ramp unchanged"}, int'(ramp), C_CLMP);
            uv_flags = '0;
            ot_lo    = 1'b0;
            step(1);
            chk({tag, " fault clears"}, int'(fault), 0);
        end

        // R6: exact reporting delay
        uv_flags = 3'b001;
        out_en   = 3'b001;
        step(U_DLY - 1);
        chk("R6 not yet", int'(fault), 0);
        step(1);
        chk("R6 reported", int'(fault), 1);
        uv_flags = '0;
        step(1);
        chk("R6 released", int'(fault), 0);

        // R8: shutdown request
        shdn_req = 1'b1;
        ot_lo    = 1'b1;
        step(1);
        chk("R8 fault forced low", int'(fault), 0);
        chk("R8 pwr_kill", int'(pwr_kill), 1);
        chk("R8 ramp zero", int'(ramp), 0);
        chk("R8 uv_en off", int'(uv_en), 0);
        step(5);
        chk("R8 held off", int'(pwr_kill), 1);
        shdn_req = 1'b0;
        ot_lo    = 1'b0;
        step(1);
        chk("R8 restart", int'(pwr_kill), 0);
        step(1);
        chk("R8 restart fast code", int'(ramp), C_FAST);
        chk("R3 held through shutdown", int'(vsel), 1);
        wait_run("R8");

        // R9: thermal latch
        ot_hi = 1'b1;
        step(1);
        ot_hi = 1'b0;
        chk("R9 fault", int'(fault), 1);
        step(1);
        chk("R9 kill", int'(pwr_kill), 1);
        step(20);
        chk("R9 latched kill", int'(pwr_kill), 1);
        chk("R9 latched fault", int'(fault), 1);
        shdn_req = 1'b1;
        step(2);
        shdn_req = 1'b0;
        step(3);
        chk("R9 survives shutdown pulse", int'(pwr_kill), 1);
        chk("R9 fault after pulse", int'(fault), 1);

        // R10: loss of standby rail
        por_ok = 1'b0;
        step(1);
        chk("R10 pwr_kill", int'(pwr_kill), 1);
        chk("R10 ramp", int'(ramp), 0);
        chk("R10 uv_en", int'(uv_en), 0);
        chk("R10 latch cleared", int'(fault), 0);
        step(3);

        // R3: new power-on event captures a new value
        power_up(1'b1, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule